// File: doc/BRIEF.md
# Seconds Prescaler with External Test Clock

This block turns a slow timekeeping source into a one-second strobe for a downstream time counter. In normal operation the source is a 64 Hz tick strobe that arrives in the system clock domain. A six-stage binary chain counts source events and produces one strobe for every 64 of them.

For board-level test, a mode input switches the source to an external clock pin. That clock is asynchronous, so it passes through a synchroniser, and each rising edge it makes counts as one source event. Test equipment can then run timekeeping much faster than real time. The mode switch does not resynchronise the chain, so its phase is unknown after the switch. A hold input clears the chain and keeps it at zero. When the hold is released, the chain starts from a known phase: the first strobe comes after 32 source events, and each later strobe after 64 more.

Top module: `rtc_prescaler`

## Requirements
- R1: While rst_n is low, sec_pulse is 0 and the chain is cleared. Counting from reset release, the first strobe follows the 32nd source event.
- R2: With test_en=0, every cycle with tick64=1 is one source event. After a clear, strobes follow source events 32, 96, 160 and so on.
- R3: With test_en=1, every 0-to-1 transition of ext_clk is one source event. The count follows the same 32/96/160 schedule.
- R4: With test_en=0, transitions on ext_clk have no effect on the chain. With test_en=1, tick64 has no effect on the chain.
- R5: While stop=1, the chain stays at zero, source events are not counted, and sec_pulse stays 0.
- R6: After stop falls, the first strobe follows the 32nd source event, whatever the chain held before stop. Each later strobe follows 64 further events.
- R7: sec_pulse is high for exactly one system-clock cycle per strobe.
- R8: When ext_clk rises and remains stable for the next three system-clock rising edges, the resulting strobe is visible right after the third of those edges.
- R9: ext_clk high and low phases as short as three system-clock cycles are each counted with no edge lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick64 | input | 1 | Internal 64 Hz source strobe, one cycle wide |
| test_en | input | 1 | 1 selects ext_clk as the source |
| ext_clk | input | 1 | Asynchronous external test clock |
| stop | input | 1 | Clears the chain and holds it |
| sec_pulse | output | 1 | One-cycle seconds-increment strobe |

## Verification
The embedded properties check several rules on every cycle. The chain advances by exactly one on a source event and holds otherwise. The hold input suppresses strobes. A strobe is never wider than one cycle and only appears at the half-count phase. An external edge registers for one cycle only. The bench scenarios cover the rest: the 32/96/160 schedule in both modes, the ignored source in each mode, re-phasing after a mid-count stop, and the three-cycle latency from an external edge to its strobe.

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int STAGES  = 6,
  parameter int SYNC_FF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick64,
  input  logic test_en,
  input  logic ext_clk,
  input  logic stop,
  output logic sec_pulse
);
  localparam int HALF = 1 << (STAGES - 1);

  logic [SYNC_FF-1:0] sync_q;
  logic               ext_prev;
  logic [STAGES-1:0]  chain;
  logic               ext_rise;
  logic               src_edge;
  logic               at_half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      ext_prev <= 1'b0;
    end else begin
      sync_q   <= {sync_q[SYNC_FF-2:0], ext_clk};
      ext_prev <= sync_q[SYNC_FF-1];
    end
  end

  assign ext_rise = sync_q[SYNC_FF-1] & ~ext_prev;
  assign src_edge = test_en ? ext_rise : tick64;
  assign at_half  = (chain == STAGES'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain     <= '0;
      sec_pulse <= 1'b0;
    end else begin
      sec_pulse <= !stop && src_edge && at_half;
      if (stop)
        chain <= '0;
      else if (src_edge)
        chain <= chain + STAGES'(1);
    end
  end

  // R2 R3
  cnt_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop && src_edge) |=> (chain == $past(chain) + STAGES'(1)));

  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop && !src_edge) |=> $stable(chain));

  // R5
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !sec_pulse);

  // R7
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |=> !sec_pulse);

  // R6
  pulse_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |-> (chain == STAGES'(HALF)));

  // R9
  edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rise |=> !ext_rise);
endmodule

// File: tb/rtc_prescaler_tb.sv
module rtc_prescaler_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick64 = 1'b0;
  logic test_en = 1'b0;
  logic ext_clk = 1'b0;
  logic stop = 1'b0;
  logic sec_pulse;

  int errors = 0;
  int checks = 0;
  int pulses = 0;
  int wide   = 0;
  logic last_p = 1'b0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  rtc_prescaler u_dut (
    .clk(clk), .rst_n(rst_n), .tick64(tick64), .test_en(test_en),
    .ext_clk(ext_clk), .stop(stop), .sec_pulse(sec_pulse)
  );

  always @(negedge clk) begin
    if (sec_pulse) pulses++;
    if (sec_pulse && last_p) wide++;
    last_p = sec_pulse;
  end

  localparam int NV = 8;
  localparam int V_MODE [NV] = '{1, 1, 1, 1, 1, 0, 0, 1};
  localparam int V_EDGE [NV] = '{31, 32, 95, 96, 160, 32, 96, 224};
  localparam int V_EXP  [NV] = '{0, 1, 1, 2, 3, 1, 2, 4};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ext_edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ext_clk = 1'b1;
      repeat (3) @(negedge clk);
      ext_clk = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick64 = 1'b1;
      @(negedge clk) tick64 = 1'b0;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic restart(input int mode);
    @(negedge clk);
    test_en = mode[0];
    stop = 1'b1;
    repeat (2) @(negedge clk);
    stop = 1'b0;
    @(negedge clk);
    pulses = 0;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset pulse", int'(sec_pulse), 0);
    rst_n = 1'b1;
    pulses = 0;
    ticks(31);
    check("R1 no strobe before 32 from reset", pulses, 0);
    ticks(1);
    check("R1 strobe at 32 from reset", pulses, 1);

    for (int v = 0; v < NV; v++) begin
      restart(V_MODE[v]);
      if (V_MODE[v] == 1) ext_edges(V_EDGE[v]); else ticks(V_EDGE[v]);
      check(V_MODE[v] == 1 ? "R3 ext schedule" : "R2 tick schedule", pulses, V_EXP[v]);
    end
    check("R7 one-cycle strobe", wide, 0);
    check("R9 short ext phases counted", pulses, 4);

    restart(0);
    ext_edges(40);
    check("R4 ext ignored in normal mode", pulses, 0);
    ticks(32);
    check("R4 chain untouched by ext", pulses, 1);

    restart(1);
    ticks(40);
    check("R4 tick ignored in test mode", pulses, 0);
    ext_edges(32);
    check("R4 chain untouched by tick", pulses, 1);

    @(negedge clk) stop = 1'b1;
    pulses = 0;
    ext_edges(100);
    check("R5 no strobe while stopped", pulses, 0);
    @(negedge clk) stop = 1'b0;
    ext_edges(31);
    check("R5 edges during stop not counted", pulses, 0);

    restart(1);
    ext_edges(20);
    @(negedge clk) stop = 1'b1;
    @(negedge clk) stop = 1'b0;
    ext_edges(31);
    check("R6 re-phase after mid-count stop", pulses, 0);
    ext_edges(1);
    check("R6 first strobe at 32", pulses, 1);
    ext_edges(63);
    check("R6 no strobe before 64 more", pulses, 1);
    ext_edges(1);
    check("R6 strobe after 64 more", pulses, 2);

    restart(1);
    ext_edges(31);
    @(negedge clk) ext_clk = 1'b1;
    repeat (2) @(posedge clk);
    #1 check("R8 no strobe after two edges", int'(sec_pulse), 0);
    @(posedge clk);
    #1 check("R8 strobe after third edge", int'(sec_pulse), 1);
    @(negedge clk) ext_clk = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 strobe width", wide, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule